// File: doc/BRIEF.md
# Three-Point Neighbourhood Update Sequencer

This block keeps a one-dimensional array of signed words in a single-port synchronous RAM and smooths one element at a time. A slow-rate update strobe, which comes from outside the fast clock domain, names an index. After a short synchroniser, a fast-clock sequencer takes that index and reads three words through the one RAM port: the word below the index, the word at the index and the word above it. It then blends the three values with a fixed 1-2-1 weighting and writes the blended value back to the same index. The whole read-modify-write finishes well inside one slow period.

The sequencer shares the RAM port with a host write path, and host writes always win. When a host write takes the port, the sequencer waits for that cycle and then carries on from where it stopped. Reads past either end of the array are never issued. A zero takes the place of the missing neighbour. The three operands and the blended result of the latest sequence stay on output ports until the next sequence overwrites them.

Top module: `nbr_top`

## Requirements
- R1: After reset, `busy` and `done` are low, and `res_left`, `res_centre`, `res_right` and `res_value` are all zero.
- R2: A rising edge on `upd_strobe` is detected after a two-flop synchroniser, and each rising edge starts exactly one sequence, however long the strobe stays high.
- R3: A sequence for index a fetches the words at a-1, a and a+1, in that order, and presents them on `res_left`, `res_centre` and `res_right`. `upd_index` must stay stable from the strobe until `done`.
- R4: For a = 0 the left operand is 0, and for a = 2^ADDR_W-1 the right operand is 0. No read address ever wraps around the array.
- R5: `res_value` equals floor((left + 2*centre + right) / 4). All operands are read as two's-complement signed values of DATA_W bits, and the sum is formed at full width before the arithmetic shift right by two.
- R6: The blended value is written to index a before `done` is raised. A later sequence that touches a sees the new value.
- R7: A host write (`host_we` high) takes the RAM port in its cycle and always lands. A sequence that runs alongside host writes stalls and still returns the correct operands and result.
- R8: `busy` is high from the cycle after the start through the write-back. `done` is a single-cycle pulse that rises in the same cycle that `busy` falls.
- R9: Without host writes, `done` appears no more than 10 fast cycles after `upd_strobe` rises.
- R10: A strobe edge that arrives while a sequence is running is held and starts one further sequence once the current one has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_strobe | input | 1 | Slow-domain update strobe (asynchronous) |
| upd_index | input | ADDR_W | Index to update, held stable during the sequence |
| host_we | input | 1 | Host write request, highest priority on the RAM port |
| host_addr | input | ADDR_W | Host write address |
| host_wdata | input | DATA_W | Host write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the write-back has completed |
| res_left | output | DATA_W | Left operand of the latest sequence |
| res_centre | output | DATA_W | Centre operand of the latest sequence |
| res_right | output | DATA_W | Right operand of the latest sequence |
| res_value | output | DATA_W | Blended value written back by the latest sequence |

## Verification
Every index of a 16-word array is swept three times: once over a ramp that holds mixed positive and negative values, once with every word at the largest positive value, and once with every word at the most negative value. The ramp shows whether the operand order and the addressing are right. It also exercises the floor rounding of negative sums. The two uniform fills push the widened sum to its extremes and so expose any overflow in the blend. The sweeps reach both array ends and a run of repeated updates on one index, which shows that each result was written back. Further patterns cover a burst of host writes in the middle of a fetch, a second strobe while the block is busy, and a strobe held high for many cycles.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

    // Order in which the three neighbour operands are fetched.
    typedef enum logic [1:0] {
        SLOT_LEFT   = 2'd0,
        SLOT_CENTRE = 2'd1,
        SLOT_RIGHT  = 2'd2
    } slot_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_FETCH,
        SQ_DRAIN,
        SQ_WRITE
    } sq_state_e;

    // Tag that goes with a read while it is in flight through the RAM latency.
    typedef struct packed {
        logic  vld;
        slot_e slot;
        logic  zero;   // boundary slot: no read issued, operand is zero
    } cap_t;

    function automatic slot_e slot_next(slot_e s);
        case (s)
            SLOT_LEFT:   return SLOT_CENTRE;
            SLOT_CENTRE: return SLOT_RIGHT;
            default:     return SLOT_RIGHT;
        endcase
    endfunction

endpackage

// File: rtl/nbr_sync.sv
module nbr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_out
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[STAGES-1];
    end

    assign rise_out = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/nbr_ram.sv
module nbr_ram #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 12
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // One port, one cycle of read latency; rdata holds across writes.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end
endmodule

// File: rtl/nbr_seq.sv
module nbr_seq
    import nbr_pkg::*;
#(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] index,
    input  logic              port_taken,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] cur_index,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] op_left,
    output logic [DATA_W-1:0] op_centre,
    output logic [DATA_W-1:0] op_right,
    output logic [DATA_W-1:0] result
);
    localparam logic [ADDR_W-1:0] IDX_LAST = '1;
    localparam int unsigned       ACC_W    = DATA_W + 2;

    sq_state_e         state_q;
    slot_e             slot_q;
    cap_t              cap_q;
    logic [ADDR_W-1:0] idx_q;
    logic              pend_q;
    logic              done_q;
    logic [DATA_W-1:0] opl_q, opc_q, opr_q, res_q;

    logic [ADDR_W-1:0] fetch_addr;
    logic              fetch_skip;
    logic              grant;
    logic signed [ACC_W-1:0] acc;
    logic [DATA_W-1:0] blend;

    assign grant = ~port_taken;

    // Neighbour address for the current slot, with the array ends clamped.
    always_comb begin
        fetch_addr = idx_q;
        fetch_skip = 1'b0;
        case (slot_q)
            SLOT_LEFT: begin
                fetch_addr = idx_q - 1'b1;
                fetch_skip = (idx_q == '0);
            end
            SLOT_RIGHT: begin
                fetch_addr = idx_q + 1'b1;
                fetch_skip = (idx_q == IDX_LAST);
            end
            default: begin
                fetch_addr = idx_q;
                fetch_skip = 1'b0;
            end
        endcase
    end

    // 1-2-1 blend at full width, then an arithmetic shift right by two.
    always_comb begin
        acc = ACC_W'($signed(opl_q))
            + (ACC_W'($signed(opc_q)) <<< 1)
            + ACC_W'($signed(opr_q));
        blend = DATA_W'(acc >>> 2);
    end

    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = fetch_addr;
        mem_wdata = blend;
        if (state_q == SQ_FETCH) begin
            mem_en = grant & ~fetch_skip;
        end else if (state_q == SQ_WRITE) begin
            mem_en   = grant;
            mem_we   = 1'b1;
            mem_addr = idx_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            slot_q  <= SLOT_LEFT;
            cap_q   <= '0;
            idx_q   <= '0;
            pend_q  <= 1'b0;
            done_q  <= 1'b0;
            opl_q   <= '0;
            opc_q   <= '0;
            opr_q   <= '0;
            res_q   <= '0;
        end else begin
            done_q    <= 1'b0;
            cap_q.vld <= 1'b0;

            if (cap_q.vld) begin
                case (cap_q.slot)
                    SLOT_LEFT:   opl_q <= cap_q.zero ? '0 : mem_rdata;
                    SLOT_CENTRE: opc_q <= cap_q.zero ? '0 : mem_rdata;
                    default:     opr_q <= cap_q.zero ? '0 : mem_rdata;
                endcase
            end

            if (start && state_q != SQ_IDLE) pend_q <= 1'b1;

            case (state_q)
                SQ_IDLE: begin
                    if (start || pend_q) begin
                        idx_q   <= index;
                        slot_q  <= SLOT_LEFT;
                        pend_q  <= 1'b0;
                        state_q <= SQ_FETCH;
                    end
                end
                SQ_FETCH: begin
                    if (grant) begin
                        cap_q <= '{vld: 1'b1, slot: slot_q, zero: fetch_skip};
                        if (slot_q == SLOT_RIGHT) state_q <= SQ_DRAIN;
                        else                      slot_q  <= slot_next(slot_q);
                    end
                end
                SQ_DRAIN: begin
                    state_q <= SQ_WRITE;
                end
                default: begin
                    if (grant) begin
                        res_q   <= blend;
                        done_q  <= 1'b1;
                        state_q <= SQ_IDLE;
                    end
                end
            endcase
        end
    end

    assign cur_index = idx_q;
    assign busy      = (state_q != SQ_IDLE);
    assign done      = done_q;
    assign op_left   = opl_q;
    assign op_centre = opc_q;
    assign op_right  = opr_q;
    assign result    = res_q;
endmodule

// File: rtl/nbr_top.sv
module nbr_top #(
    parameter int unsigned ADDR_W      = 11,
    parameter int unsigned DATA_W      = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_strobe,
    input  logic [ADDR_W-1:0] upd_index,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] res_left,
    output logic [DATA_W-1:0] res_centre,
    output logic [DATA_W-1:0] res_right,
    output logic [DATA_W-1:0] res_value
);
    logic              start;
    logic              seq_en, seq_we;
    logic [ADDR_W-1:0] seq_addr;
    logic [DATA_W-1:0] seq_wdata;
    logic [ADDR_W-1:0] seq_index;
    logic              mem_en, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    nbr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (upd_strobe),
        .rise_out (start)
    );

    nbr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .index      (upd_index),
        .port_taken (host_we),
        .mem_en     (seq_en),
        .mem_we     (seq_we),
        .mem_addr   (seq_addr),
        .mem_wdata  (seq_wdata),
        .mem_rdata  (mem_rdata),
        .cur_index  (seq_index),
        .busy       (busy),
        .done       (done),
        .op_left    (res_left),
        .op_centre  (res_centre),
        .op_right   (res_right),
        .result     (res_value)
    );

    // Port arbitration: the host write owns the port whenever it asks.
    always_comb begin
        if (host_we) begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = host_addr;
            mem_wdata = host_wdata;
        end else begin
            mem_en    = seq_en;
            mem_we    = seq_we;
            mem_addr  = seq_addr;
            mem_wdata = seq_wdata;
        end
    end

    nbr_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .en    (mem_en),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );
endmodule

// File: rtl/nbr_chk.sv
module nbr_chk #(
    parameter int unsigned ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              host_we,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] seq_index,
    input logic              busy,
    input logic              done
);
    localparam logic [ADDR_W-1:0] IDX_LAST = '1;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                            // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                            // R8
    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);                                      // R8
    AST_WB_NOT_HOST: assert property (@(posedge clk) disable iff (rst)
        done |-> !$past(host_we));                                  // R7
    AST_INDEX_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(seq_index));              // R3
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !mem_we && !host_we) |->
            (mem_addr == seq_index
             || (seq_index != '0 && mem_addr == ADDR_W'(seq_index - 1'b1))
             || (seq_index != IDX_LAST && mem_addr == ADDR_W'(seq_index + 1'b1)))); // R4
    AST_WB_ADDR: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !host_we) |-> (mem_addr == seq_index && busy));  // R6
endmodule

bind nbr_top nbr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .host_we   (host_we),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .seq_index (seq_index),
    .busy      (busy),
    .done      (done)
);

// File: tb/tb_nbr_top.sv
module tb_nbr_top;
    localparam int AW = 4;
    localparam int DW = 12;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          upd_strobe = 1'b0;
    logic [AW-1:0] upd_index  = '0;
    logic          host_we    = 1'b0;
    logic [AW-1:0] host_addr  = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          busy, done;
    logic [DW-1:0] res_left, res_centre, res_right, res_value;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;
    int model [N];

    always #5 clk = ~clk;

    nbr_top #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .upd_strobe(upd_strobe), .upd_index(upd_index),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .busy(busy), .done(done), .res_left(res_left), .res_centre(res_centre),
        .res_right(res_right), .res_value(res_value)
    );

    function automatic int sx(logic [DW-1:0] v);
        return int'($signed(v));
    endfunction

    function automatic int blend(int l, int c, int r);
        return (l + 2 * c + r) >>> 2;
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic host_write(int a, int d);
        host_we    = 1'b1;
        host_addr  = AW'(a);
        host_wdata = DW'(d);
        @(negedge clk);
        host_we = 1'b0;
        model[a] = sx(DW'(d));
    endtask

    task automatic fill(int mode);
        for (int a = 0; a < N; a++) begin
            int v;
            case (mode)
                0: v = (a * 419) - 2048 + (a % 3) * 7;
                1: v = 2047;
                default: v = -2048;
            endcase
            host_write(a, v);
        end
    endtask

    // Runs one sequence on idx and checks operands, result and timing.
    task automatic run_seq(int idx, int max_cyc);
        int el, ec, er, ev, cyc;
        bit seen;
        el = (idx == 0)     ? 0 : model[idx-1];
        ec = model[idx];
        er = (idx == N - 1) ? 0 : model[idx+1];
        ev = blend(el, ec, er);
        upd_index  = AW'(idx);
        upd_strobe = 1'b1;
        cyc  = 0;
        seen = 1'b0;
        while (!seen && cyc < 60) begin
            @(negedge clk);
            cyc++;
            if (cyc == 4) upd_strobe = 1'b0;
            if (done) seen = 1'b1;
        end
        upd_strobe = 1'b0;
        check("R9 done seen", int'(seen), 1);
        if (cyc > max_cyc) check("R9 latency", cyc, max_cyc);
        check("R8 busy low at done", int'(busy), 0);
        check("R3 left", sx(res_left), el);
        check("R3 centre", sx(res_centre), ec);
        check("R3 right", sx(res_right), er);
        check("R5 blend", sx(res_value), sx(DW'(ev)));
        model[idx] = sx(DW'(ev));
        @(negedge clk);
        check("R8 done one cycle", int'(done), 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 outputs", int'(res_left | res_centre | res_right | res_value), 0);

        // Sweeps over all indices, ends included (R3, R4, R5).
        for (int m = 0; m < 3; m++) begin
            fill(m);
            for (int i = 0; i < N; i++) run_seq(i, 10);
        end

        // Repeated updates on one index read back the written value (R6).
        fill(0);
        for (int k = 0; k < 4; k++) run_seq(6, 10);
        run_seq(5, 10);   // R6: right neighbour is the value written to 6
        run_seq(7, 10);   // R6: left neighbour is the value written to 6

        // Host burst in the middle of a fetch (R7).
        fork
            run_seq(8, 40);
            begin
                repeat (3) @(negedge clk);
                for (int b = 0; b < 5; b++) host_write(2, 100 + b * 37);
            end
        join
        run_seq(3, 10);   // R7: left operand shows the last host write
        check("R7 host data landed", model[2], 100 + 4 * 37);

        // Strobe held high for a long time gives one sequence only (R2).
        begin
            int dones = 0;
            upd_index = AW'(11);
            upd_strobe = 1'b1;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (done) dones++;
            end
            upd_strobe = 1'b0;
            repeat (4) @(negedge clk);
            check("R2 one sequence per edge", dones, 1);
            model[11] = sx(res_value);
        end

        // Second strobe edge while busy is held and served (R10).
        begin
            int dones = 0;
            int e1, e2;
            e1 = blend(model[9], model[10], model[11]);
            e2 = blend(model[9], sx(DW'(e1)), model[11]);
            upd_index = AW'(10);
            for (int c = 0; c < 40; c++) begin
                upd_strobe = (c < 3) || (c >= 5 && c < 8);
                @(negedge clk);
                if (done) dones++;
            end
            upd_strobe = 1'b0;
            check("R10 pending sequences", dones, 2);
            check("R10 second result", sx(res_value), sx(DW'(e2)));
            check("R10 second centre", sx(res_centre), sx(DW'(e1)));
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule